// File: doc/BRIEF.md
# Tone-Pair Steering and Code Latch

This block sits after a dual-tone classifier. It turns the classifier's raw "both tones seen" flag into a registered keypad digit. A fixed external RC steering network would normally do this work. Here two guard windows, counted in clock cycles, take its place. The tone-present window rejects bursts that are too short. The tone-absent window lets the block ride through brief dropouts and validates the pause between digits. When a tone pair has lasted for the whole present window, the block captures its 4-bit keypad code. After a fixed settling interval it raises a delayed-steering flag. That flag stays up until a full absent window of silence has been seen.

The code sits in a holding register and stays there until the next digit is registered. There is no back-pressure. A consumer samples `dout` when `steer_dly` rises, or at any later time before the next registration. The output enable does the job of a three-state bus enable. While it is low, the data output is forced to zero and `dout_vld` drops. The register contents are left unchanged. `guard_out` reports whether the steering machine is holding a digit, in the settle phase or in the held phase, so that a host can observe it.

Top module: `tone_steer_latch`

## Requirements
- R1: After reset, `steer_dly`, `guard_out` and the latched code are all 0.
- R2: A run of `early_ok` high that is shorter than `present_guard` cycles registers nothing. A fall of `early_ok` restarts the present count, so two short runs split by one low cycle also register nothing.
- R3: The code is latched at the clock edge that samples the `present_guard`-th consecutive high cycle of `early_ok`. It is taken from `row_idx`/`col_idx` as they stand at that edge, and `steer_dly` is still 0 at that point.
- R4: `steer_dly` rises exactly `SETTLE_CYC` clock edges after the code is latched. The code does not change between the latch and the later clear of `steer_dly`.
- R5: While `steer_dly` is high, it falls at the edge that samples the `absent_guard`-th consecutive low cycle of `early_ok`.
- R6: A run of `early_ok` low that is shorter than `absent_guard` leaves `steer_dly` high. A tone that follows such a dropout, even one with different indices, registers no new code.
- R7: `present_guard` and `absent_guard` take effect independently of each other. A value of 0 acts as 1.
- R8: Rows 0..3 and columns 0..2 map to digits 1..9 by the rule row*3+col+1. Row 3 gives 1011 (star) at column 0, 1010 (zero) at column 1 and 1100 (hash) at column 2. Column 3 gives 1101, 1110 and 1111 for rows 0..2 and 0000 for row 3.
- R9: When `out_en` is 0, `dout` is 0 and `dout_vld` is 0. When `out_en` is 1, `dout` shows the last latched code and `dout_vld` is 1.
- R10: `guard_out` is 1 from the latch edge until the edge that clears `steer_dly`, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| early_ok | input | 1 | Classifier flag: both tones currently valid |
| row_idx | input | 2 | Low-group tone index 0..3 |
| col_idx | input | 2 | High-group tone index 0..3 |
| present_guard | input | 16 | Tone-present guard time in cycles |
| absent_guard | input | 16 | Tone-absent guard time in cycles |
| out_en | input | 1 | Output enable for the code bus |
| dout | output | 4 | Latched keypad code, masked by `out_en` |
| dout_vld | output | 1 | High while the code bus is enabled |
| steer_dly | output | 1 | Delayed steering flag |
| guard_out | output | 1 | Steering state: a digit is in settle or held phase |

## Verification
The bench keeps the default `SETTLE_CYC` of 4 and starts with guard times of 6 present and 5 absent cycles. These small values let it probe each window boundary on the exact edge, at one cycle short and at one cycle reached, in a few dozen cycles. Partway through, it switches to 3 present and 8 absent cycles. This shows that the two windows are independent and that the boundaries follow the programmed values rather than fixed ones. With the short windows, all sixteen row and column pairs pass through the scoreboard well within the run limit.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } steer_state_t;
endpackage

// File: rtl/tsl_code_map.sv
module tsl_code_map #(
  parameter int IDX_W  = 2,
  parameter int CODE_W = 4
) (
  input  logic [IDX_W-1:0]  row,
  input  logic [IDX_W-1:0]  col,
  output logic [CODE_W-1:0] code
);
  localparam int LAST = (1 << IDX_W) - 1;

  always_comb begin
    if (int'(col) == LAST) begin
      // extra column: letters, last row wraps to all zeros
      code = (int'(row) == LAST) ? '0 : CODE_W'(13 + int'(row));
    end else if (int'(row) == LAST) begin
      case (int'(col))
        0:       code = CODE_W'(11);
        1:       code = CODE_W'(10);
        default: code = CODE_W'(12);
      endcase
    end else begin
      code = CODE_W'(int'(row) * 3 + int'(col) + 1);
    end
  end
endmodule

// File: rtl/tsl_guard_counter.sv
module tsl_guard_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          hit
);
  logic [CW-1:0] cnt;

  // hit when the cycle now being counted is the limit-th one (limit 0 acts as 1)
  assign hit = ({1'b0, cnt} + {{CW{1'b0}}, 1'b1}) >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc)      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tsl_steer_fsm.sv
module tsl_steer_fsm
  import tsl_pkg::*;
#(
  parameter int GW         = 16,
  parameter int SETTLE_CYC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          early,
  input  logic [GW-1:0] t_present,
  input  logic [GW-1:0] t_absent,
  output logic          latch,
  output logic          steer,
  output logic          busy
);
  localparam logic [GW-1:0] SETTLE_LIM = GW'(SETTLE_CYC);

  steer_state_t st, st_nx;
  logic          clr, inc, hit;
  logic [GW-1:0] lim;

  tsl_guard_counter #(.CW(GW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc), .limit(lim), .hit(hit)
  );

  always_comb begin
    st_nx = st;
    clr   = 1'b0;
    inc   = 1'b0;
    latch = 1'b0;
    lim   = t_present;
    unique case (st)
      ST_IDLE: begin
        lim = t_present;
        if (!early)   clr = 1'b1;
        else if (hit) begin latch = 1'b1; clr = 1'b1; st_nx = ST_SETTLE; end
        else          inc = 1'b1;
      end
      ST_SETTLE: begin
        lim = SETTLE_LIM;
        if (hit) begin clr = 1'b1; st_nx = ST_HELD; end
        else     inc = 1'b1;
      end
      ST_HELD: begin
        lim = t_absent;
        if (early)    clr = 1'b1;
        else if (hit) begin clr = 1'b1; st_nx = ST_IDLE; end
        else          inc = 1'b1;
      end
      default: begin clr = 1'b1; st_nx = ST_IDLE; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nx;
  end

  assign steer = (st == ST_HELD);
  assign busy  = (st != ST_IDLE);
endmodule

// File: rtl/tone_steer_latch.sv
module tone_steer_latch #(
  parameter int GW         = 16,
  parameter int SETTLE_CYC = 4,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             early_ok,
  input  logic [IDX_W-1:0] row_idx,
  input  logic [IDX_W-1:0] col_idx,
  input  logic [GW-1:0]    present_guard,
  input  logic [GW-1:0]    absent_guard,
  input  logic             out_en,
  output logic [3:0]       dout,
  output logic             dout_vld,
  output logic             steer_dly,
  output logic             guard_out
);
  localparam int CODE_W = 4;

  logic              latch;
  logic [CODE_W-1:0] mapped, code_q;

  tsl_code_map #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_map (
    .row(row_idx), .col(col_idx), .code(mapped)
  );

  tsl_steer_fsm #(.GW(GW), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .early(early_ok),
    .t_present(present_guard), .t_absent(absent_guard),
    .latch(latch), .steer(steer_dly), .busy(guard_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)     code_q <= '0;
    else if (latch) code_q <= mapped;
  end

  assign dout     = out_en ? code_q : '0;
  assign dout_vld = out_en;
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       early_ok,
  input logic       out_en,
  input logic [3:0] dout,
  input logic       dout_vld,
  input logic       steer_dly,
  input logic       guard_out
);
  p_reg_needs_tone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(guard_out) |-> $past(early_ok));

  p_code_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_out && $past(guard_out) && out_en && $past(out_en)) |-> $stable(dout));

  p_rise_after_settle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(steer_dly) |-> $past(guard_out));

  p_clear_on_silence_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(steer_dly) |-> !$past(early_ok));

  p_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (dout == 4'd0 && !dout_vld));

  p_steer_in_guard_r10: assert property (@(posedge clk) disable iff (!rst_n)
    steer_dly |-> guard_out);
endmodule

bind tone_steer_latch tsl_checker u_chk (
  .clk(clk), .rst_n(rst_n), .early_ok(early_ok), .out_en(out_en),
  .dout(dout), .dout_vld(dout_vld), .steer_dly(steer_dly), .guard_out(guard_out)
);

// File: tb/sim_tone_steer_latch.sv
module sim_tone_steer_latch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        early_ok = 1'b0;
  logic [1:0]  row_idx = '0, col_idx = '0;
  logic [15:0] present_guard = 16'd6, absent_guard = 16'd5;
  logic        out_en = 1'b1;
  logic [3:0]  dout;
  logic        dout_vld, steer_dly, guard_out;

  int n_cmp = 0, n_bad = 0, rises = 0;
  bit done = 0;
  logic [3:0] exp_q[$];

  always #2 clk = ~clk;

  tone_steer_latch u0 (
    .clk(clk), .rst_n(rst_n), .early_ok(early_ok), .row_idx(row_idx), .col_idx(col_idx),
    .present_guard(present_guard), .absent_guard(absent_guard), .out_en(out_en),
    .dout(dout), .dout_vld(dout_vld), .steer_dly(steer_dly), .guard_out(guard_out)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] key_code(int r, int c);
    string pad = "123A456B789C*0#D";
    byte k = pad[r*4 + c];
    if (k >= "1" && k <= "9") return 4'(k - "0");
    if (k == "0") return 4'd10;
    if (k == "*") return 4'd11;
    if (k == "#") return 4'd12;
    if (k == "D") return 4'd0;
    return 4'(k - "A" + 13);
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: schedule the expected code, then play the tone
  task automatic send_digit(int r, int c, int hi, int lo);
    exp_q.push_back(key_code(r, c));
    row_idx = 2'(r); col_idx = 2'(c);
    early_ok = 1'b1; cyc(hi);
    early_ok = 1'b0; cyc(lo);
  endtask

  // monitor: every registration must match the head of the queue
  initial begin
    forever begin
      @(posedge steer_dly);
      @(negedge clk);
      rises++;
      if (exp_q.size() == 0) chk("R6 unexpected registration", rises, rises - 1);
      else chk("R8 code", int'(dout), int'(exp_q.pop_front()));
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk("R1 steer", steer_dly, 0);
    chk("R1 guard", guard_out, 0);
    chk("R1 code", dout, 0);
    rst_n = 1'b1; cyc(2);

    // R2: short bursts, and two short runs split by one low cycle
    row_idx = 2'd1; col_idx = 2'd1;
    early_ok = 1'b1; cyc(5); early_ok = 1'b0; cyc(1);
    early_ok = 1'b1; cyc(5); early_ok = 1'b0; cyc(10);
    chk("R2 steer", steer_dly, 0);
    chk("R2 guard", guard_out, 0);
    chk("R2 rises", rises, 0);

    // R3/R4/R10: valid tone, digit 1
    exp_q.push_back(key_code(0, 0));
    row_idx = 2'd0; col_idx = 2'd0; early_ok = 1'b1;
    cyc(5);
    chk("R3 not yet latched", guard_out, 0);
    cyc(1);
    chk("R3 code latched", dout, 1);
    chk("R3 steer low at latch", steer_dly, 0);
    chk("R10 guard at latch", guard_out, 1);
    cyc(3);
    chk("R4 steer before settle", steer_dly, 0);
    cyc(1);
    chk("R4 steer after settle", steer_dly, 1);
    chk("R4 code held", dout, 1);

    // R6: dropout one short of the absent window, then a different pair
    early_ok = 1'b0; cyc(4);
    row_idx = 2'd2; col_idx = 2'd2; early_ok = 1'b1; cyc(12);
    chk("R6 steer held", steer_dly, 1);
    chk("R6 code kept", dout, 1);
    chk("R6 rises", rises, 1);

    // R9: output mask
    out_en = 1'b0; cyc(1);
    chk("R9 masked data", dout, 0);
    chk("R9 masked valid", dout_vld, 0);
    out_en = 1'b1; cyc(1);
    chk("R9 restored data", dout, 1);
    chk("R9 restored valid", dout_vld, 1);

    // R5/R10: valid pause
    early_ok = 1'b0; cyc(4);
    chk("R5 steer before pause", steer_dly, 1);
    cyc(1);
    chk("R5 steer after pause", steer_dly, 0);
    chk("R10 guard after clear", guard_out, 0);

    // R7: independent windows, 3 present / 8 absent
    present_guard = 16'd3; absent_guard = 16'd8;
    exp_q.push_back(key_code(1, 0));
    row_idx = 2'd1; col_idx = 2'd0; early_ok = 1'b1;
    cyc(3);
    chk("R7 short present window", dout, 4);
    cyc(6);
    early_ok = 1'b0; cyc(7);
    chk("R7 steer before long pause", steer_dly, 1);
    cyc(1);
    chk("R7 steer after long pause", steer_dly, 0);

    // R7: zero acts as one
    present_guard = 16'd0; absent_guard = 16'd0;
    exp_q.push_back(key_code(3, 3));
    row_idx = 2'd3; col_idx = 2'd3; early_ok = 1'b1;
    cyc(1);
    chk("R7 zero present", guard_out, 1);
    cyc(6);
    early_ok = 1'b0; cyc(1);
    chk("R7 zero absent", steer_dly, 0);

    // R8: all sixteen pairs through the scoreboard
    present_guard = 16'd6; absent_guard = 16'd5;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        send_digit(r, c, 12, 8);
    cyc(4);
    chk("R8 all consumed", exp_q.size(), 0);
    chk("R8 registrations", rises, 19);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule